// File: doc/BRIEF.md
# Multi-Channel Modulation Select Sequencer with Echo Replay

This block drives the modulation profile-select lines of several direct digital synthesizer channels from one clock. That clock is the synthesizers' own synchronization clock, with a 16 ns period. Each transmit channel steps through its own stored code, one chip per clock. The code can use 2, 4, 8 or 16 levels. Two transmit channels carrying different orthogonal codes are the typical use.

For every transmit channel the block also drives an echo channel. The echo replays that channel's code after a programmable delay counted in whole clocks. It stands in for a target reflection: one clock of delay equals 2.4 m of simulated range. A one-clock trigger tells the receiver where each code period starts.

Software programs codes, delays, level counts and the code length through a single write port while the block is idle. A start strobe then launches all channels together. A stop strobe returns every line to code zero.

Top module: `dds_modctl`

## Requirements
- R1: During and after reset, and whenever the block is idle, every direct and echo select line is zero and the trigger is low.
- R2: Writes use cfgKind 0 to store code entry cfgAddr of channel cfgChan from cfgData[SEL_W-1:0], kind 1 to set that channel's echo delay, kind 2 to set its level code, and kind 3 to set the common last code index. A start sampled high while idle (and stop low) makes the next clock show entry 0 of every channel's code on its direct lines, with the trigger high.
- R3: While running, each direct channel advances one code entry per clock through entries 0 to the last index, then wraps back to entry 0.
- R4: The trigger is high on exactly those running clocks whose direct output is entry 0, and on no others. With a last index of 0 it is high on every running clock.
- R5: An echo channel with delay d outputs zero for the first d clocks of a run. On run clock p with p >= d it outputs entry (p - d) mod length of its source channel.
- R6: With delay 0 an echo channel is identical to its direct channel from the first clock of the run.
- R7: Any delay up to 2^DLY_W - 1 clocks works, and the default width covers delays well beyond 5000 clocks.
- R8: Level code n (cfgData[1:0]) keeps the low n+1 select bits of a channel, giving 2, 4, 8 or 16 levels. Higher bits read zero on both the direct and the echo lines.
- R9: A stop sampled high forces all select lines to zero and the trigger low on the next clock, and the block goes idle. A stop in the same cycle as a start wins.
- R10: Configuration writes made while running change nothing: neither the current run nor a later one sees them.
- R11: A start while running is ignored, and the run continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer synchronization clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe |
| stop | input | 1 | Halt strobe |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgKind | input | 2 | Write target: 0 code, 1 delay, 2 levels, 3 last index |
| cfgChan | input | CH_W | Channel addressed by the write |
| cfgAddr | input | ADDR_W | Code entry addressed by a code write |
| cfgData | input | DLY_W | Write data |
| txSel | output | NUM_TX*SEL_W | Direct select lines, channel c at bits c*SEL_W upward |
| echoSel | output | NUM_TX*SEL_W | Delayed replica select lines, same layout |
| trigger | output | 1 | Receiver trigger at each code period start |

## Verification
The bench builds the block with a 64-entry code store and a 13-bit delay. The short store makes full-depth wrap-around quick to reach. The 13-bit delay still reaches the 5000-clock echo delay and the largest delay of 8191 clocks within a short run. A one-entry code length exercises the trigger on every clock. Mixed level settings across the two channels expose masking errors that a single setting would hide.

// File: rtl/dds_modctl_pkg.sv
package dds_modctl_pkg;

  typedef struct packed {
    logic launch;
    logic step;
    logic halt;
  } strobe_t;

  typedef enum logic [1:0] {
    CFG_CODE   = 2'd0,
    CFG_DELAY  = 2'd1,
    CFG_LEVELS = 2'd2,
    CFG_LAST   = 2'd3
  } cfg_kind_e;

endpackage

// File: rtl/dds_modctl_ctrl.sv
module dds_modctl_ctrl
  import dds_modctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] lastIdx,
  output strobe_t           strb,
  output logic              running,
  output logic [ADDR_W-1:0] rdIdx,
  output logic              trigger
);

  logic [ADDR_W-1:0] idx;

  always_comb begin
    strb.launch = !running && start && !stop;
    strb.step   = running && !stop;
    strb.halt   = running && stop;
    rdIdx       = strb.launch ? '0 : idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      idx     <= '0;
      trigger <= 1'b0;
    end else begin
      if (strb.launch) running <= 1'b1;
      else if (strb.halt) running <= 1'b0;
      if (strb.launch || strb.step)
        idx <= (rdIdx == lastIdx) ? '0 : rdIdx + 1'b1;
      trigger <= strb.launch || (strb.step && idx == '0);
    end
  end

endmodule

// File: rtl/dds_modctl_path.sv
module dds_modctl_path
  import dds_modctl_pkg::*;
#(
  parameter int NUM_TX    = 2,
  parameter int SEL_W     = 4,
  parameter int SEQ_DEPTH = 1024,
  parameter int DLY_W     = 16,
  parameter int ADDR_W    = 10,
  parameter int CH_W      = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic                    running,
  input  logic [ADDR_W-1:0]       rdIdx,
  input  logic                    cfgWrEn,
  input  logic [1:0]              cfgKind,
  input  logic [CH_W-1:0]         cfgChan,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [DLY_W-1:0]        cfgData,
  output logic [NUM_TX*SEL_W-1:0] txSel,
  output logic [NUM_TX*SEL_W-1:0] echoSel,
  output logic [ADDR_W-1:0]       lastIdx
);

  logic [SEL_W-1:0] codeMem [NUM_TX][SEQ_DEPTH];
  logic [DLY_W-1:0] delayReg [NUM_TX];
  logic [1:0]       lvlReg [NUM_TX];
  logic [ADDR_W-1:0] lastReg;
  logic wrOk;
  logic chanOk;

  assign wrOk    = cfgWrEn && !running;
  assign chanOk  = int'(cfgChan) < NUM_TX;
  assign lastIdx = lastReg;

  always_ff @(posedge clk) begin
    if (wrOk && chanOk && cfgKind == CFG_CODE)
      codeMem[cfgChan][cfgAddr] <= cfgData[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastReg <= '0;
      for (int c = 0; c < NUM_TX; c++) begin
        delayReg[c] <= '0;
        lvlReg[c]   <= 2'd3;
      end
    end else if (wrOk) begin
      if (cfgKind == CFG_LAST) lastReg <= cfgData[ADDR_W-1:0];
      if (chanOk && cfgKind == CFG_DELAY) delayReg[cfgChan] <= cfgData;
      if (chanOk && cfgKind == CFG_LEVELS) lvlReg[cfgChan] <= cfgData[1:0];
    end
  end

  for (genvar g = 0; g < NUM_TX; g++) begin : g_chan
    logic [SEL_W-1:0]  mask;
    logic [SEL_W-1:0]  txOut;
    logic [SEL_W-1:0]  echoOut;
    logic [DLY_W-1:0]  remain;
    logic [ADDR_W-1:0] eIdx;
    logic [ADDR_W-1:0] echoRd;
    logic              echoHit;

    always_comb begin
      for (int b = 0; b < SEL_W; b++) mask[b] = (b <= int'(lvlReg[g]));
      echoHit = strb.launch ? (delayReg[g] == '0) : (remain == '0);
      echoRd  = strb.launch ? '0 : eIdx;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txOut   <= '0;
        echoOut <= '0;
        remain  <= '0;
        eIdx    <= '0;
      end else if (strb.halt || !(strb.launch || strb.step)) begin
        txOut   <= '0;
        echoOut <= '0;
      end else begin
        txOut <= codeMem[g][rdIdx] & mask;
        if (echoHit) begin
          echoOut <= codeMem[g][echoRd] & mask;
          eIdx    <= (echoRd == lastReg) ? '0 : echoRd + 1'b1;
          remain  <= '0;
        end else begin
          echoOut <= '0;
          remain  <= (strb.launch ? delayReg[g] : remain) - 1'b1;
          if (strb.launch) eIdx <= '0;
        end
      end
    end

    assign txSel[g*SEL_W +: SEL_W]   = txOut;
    assign echoSel[g*SEL_W +: SEL_W] = echoOut;
  end

endmodule

// File: rtl/dds_modctl.sv
module dds_modctl
  import dds_modctl_pkg::*;
#(
  parameter int NUM_TX    = 2,
  parameter int SEL_W     = 4,
  parameter int SEQ_DEPTH = 1024,
  parameter int DLY_W     = 16,
  localparam int ADDR_W   = (SEQ_DEPTH > 1) ? $clog2(SEQ_DEPTH) : 1,
  localparam int CH_W     = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    cfgWrEn,
  input  logic [1:0]              cfgKind,
  input  logic [CH_W-1:0]         cfgChan,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [DLY_W-1:0]        cfgData,
  output logic [NUM_TX*SEL_W-1:0] txSel,
  output logic [NUM_TX*SEL_W-1:0] echoSel,
  output logic                    trigger
);

  strobe_t           strb;
  logic              running;
  logic [ADDR_W-1:0] rdIdx;
  logic [ADDR_W-1:0] lastIdx;

  dds_modctl_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .lastIdx(lastIdx), .strb(strb), .running(running),
    .rdIdx(rdIdx), .trigger(trigger)
  );

  dds_modctl_path #(
    .NUM_TX(NUM_TX), .SEL_W(SEL_W), .SEQ_DEPTH(SEQ_DEPTH),
    .DLY_W(DLY_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .running(running), .rdIdx(rdIdx),
    .cfgWrEn(cfgWrEn), .cfgKind(cfgKind), .cfgChan(cfgChan),
    .cfgAddr(cfgAddr), .cfgData(cfgData),
    .txSel(txSel), .echoSel(echoSel), .lastIdx(lastIdx)
  );

endmodule

// File: rtl/dds_modctl_chk.sv
module dds_modctl_chk #(
  parameter int ADDR_W = 10,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              stop,
  input logic              running,
  input logic [ADDR_W-1:0] lastIdx,
  input logic [OUT_W-1:0]  txSel,
  input logic [OUT_W-1:0]  echoSel,
  input logic              trigger
);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (txSel == '0 && echoSel == '0 && !trigger));

  a_r2_start_trig: assert property (@(posedge clk) disable iff (!rstN)
    (!running && start && !stop) |=> (running && trigger));

  a_r4_trig_single: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && lastIdx != '0 && running) |=> !trigger);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (txSel == '0 && echoSel == '0 && !trigger && !running));

  a_r10_len_frozen: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(lastIdx));

  a_r11_keep_running: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stop) |=> running);

endmodule

bind dds_modctl dds_modctl_chk #(.ADDR_W(ADDR_W), .OUT_W(NUM_TX*SEL_W)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .stop(stop), .running(running),
  .lastIdx(lastIdx), .txSel(txSel), .echoSel(echoSel), .trigger(trigger)
);

// File: tb/test_dds_modctl.sv
module test_dds_modctl;
  localparam int NT = 2;
  localparam int SW = 4;
  localparam int DEPTH = 64;
  localparam int DW = 13;
  localparam int AW = 6;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [CW-1:0] cfgChan = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [DW-1:0] cfgData = '0;
  logic [NT*SW-1:0] txSel;
  logic [NT*SW-1:0] echoSel;
  logic trigger;

  always #5 clk = ~clk;

  dds_modctl #(.NUM_TX(NT), .SEL_W(SW), .SEQ_DEPTH(DEPTH), .DLY_W(DW)) i_dds_modctl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .cfgWrEn(cfgWrEn),
    .cfgKind(cfgKind), .cfgChan(cfgChan), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .txSel(txSel), .echoSel(echoSel), .trigger(trigger)
  );

  int mCode [NT][DEPTH];
  int mDelay [NT];
  int mLev [NT];
  int mLast;
  int mPhase;
  bit mRun;
  bit mWas;
  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit chkOn = 1'b0;
  bit done = 1'b0;
  int eLen, eMask, eTx, eEc;

  // reference model: phase counter since launch, behavioural modulo arithmetic
  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 1'b0; mPhase = 0; mLast = 0;
      for (int c = 0; c < NT; c++) begin mDelay[c] = 0; mLev[c] = 3; end
    end else begin
      mWas = mRun;
      if (cfgWrEn && !mWas) begin
        case (cfgKind)
          2'd0: mCode[cfgChan][cfgAddr] = int'(cfgData[SW-1:0]);
          2'd1: mDelay[cfgChan] = int'(cfgData);
          2'd2: mLev[cfgChan] = int'(cfgData[1:0]);
          default: mLast = int'(cfgData[AW-1:0]);
        endcase
      end
      if (!mWas) begin
        if (start && !stop) begin mRun = 1'b1; mPhase = 0; end
      end else if (stop) mRun = 1'b0;
      else mPhase++;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn && !done) begin
      eLen = mLast + 1;
      for (int c = 0; c < NT; c++) begin
        eMask = (1 << (mLev[c] + 1)) - 1;
        eTx = 0; eEc = 0;
        if (mRun) begin
          eTx = mCode[c][mPhase % eLen] & eMask;
          if (mPhase >= mDelay[c]) eEc = mCode[c][(mPhase - mDelay[c]) % eLen] & eMask;
        end
        cmp((mRun && mPhase == 0) ? "R2" : curReq, "direct", int'(txSel[c*SW +: SW]), eTx);
        cmp(curReq, "echo", int'(echoSel[c*SW +: SW]), eEc);
      end
      cmp("R4", "trigger", int'(trigger), (mRun && (mPhase % eLen == 0)) ? 1 : 0);
    end
  end

  task automatic cfg(int kind, int chan, int addr, int data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgKind = 2'(kind); cfgChan = CW'(chan);
    cfgAddr = AW'(addr); cfgData = DW'(data);
  endtask

  task automatic cfgDone();
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic loadCodes(int seed);
    for (int ch = 0; ch < NT; ch++)
      for (int a = 0; a < DEPTH; a++)
        cfg(0, ch, a, (a * (2 * ch + 3) + seed * (ch + 1) + (a >> 2)) % 16);
    cfgDone();
  endtask

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startRun();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    cmp("R1", "reset direct", int'(txSel), 0);
    cmp("R1", "reset echo", int'(echoSel), 0);
    cmp("R1", "reset trigger", int'(trigger), 0);
    rstN = 1'b1;
    chkOn = 1'b1;
    pause(3);

    loadCodes(1);
    cfg(3, 0, 0, 9); cfg(1, 0, 0, 3); cfg(1, 1, 0, 0); cfgDone();
    curReq = "R3"; startRun(); pause(15);
    curReq = "R5"; pause(20);
    curReq = "R9"; stopRun(); pause(3);

    cfg(1, 0, 0, 0); cfgDone();
    curReq = "R6"; startRun(); pause(15);
    stopRun(); pause(2);

    cfg(1, 0, 0, 4); cfgDone();
    curReq = "R10"; startRun();
    cfg(0, 0, 0, 15); cfg(3, 0, 0, 2); cfg(1, 0, 0, 7); cfg(2, 1, 0, 0); cfgDone();
    pause(5); stopRun(); pause(2);
    startRun(); pause(20);

    curReq = "R11";
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    pause(10);
    curReq = "R9";
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    pause(3);

    loadCodes(5);
    cfg(2, 0, 0, 0); cfg(2, 1, 0, 1); cfg(1, 0, 0, 1); cfg(1, 1, 0, 2); cfg(3, 0, 0, 63); cfgDone();
    curReq = "R8"; startRun(); pause(140); stopRun();
    cfg(2, 0, 0, 2); cfg(2, 1, 0, 3); cfgDone();
    startRun(); pause(20); stopRun();

    cfg(3, 0, 0, 0); cfg(1, 0, 0, 0); cfg(1, 1, 0, 1); cfgDone();
    curReq = "R4"; startRun(); pause(10); stopRun();

    cfg(3, 0, 0, 6); cfg(1, 0, 0, 5000); cfg(1, 1, 0, 8191); cfgDone();
    curReq = "R7"; startRun(); pause(8210); stopRun(); pause(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL %s watchdog actual timeout expected completion", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule